// File: doc/BRIEF.md
# Wrapped Burst Read Address Generator

This block produces the byte address sequence for quad-I/O fast-read bursts in a serial flash controller. A burst begins when the command decoder presents a start address. The block then waits for the mode byte that follows the address. After that it advances the address by one for each data byte the shifter delivers. The burst ends when chip select is released.

The address either counts straight through memory or stays inside an aligned window of 8, 16, 32 or 64 bytes. In the windowed case, stepping past the last byte of the window returns to the first byte of the same window. The window setting and the dummy-clock selection are held in registers. Both survive from one burst to the next until they are written again. Mode-switching logic elsewhere in the device leaves them alone.

The mode byte decides whether the following access may omit its opcode. That decision is presented to the decoder as a flag that persists across chip-select cycles.

The controller has three phases:
- `PH_IDLE` (0): no burst is active.
- `PH_MODE` (1): waiting for the mode byte.
- `PH_STREAM` (2): data bytes are being stepped.

The transitions between them are:
- `start`: `PH_IDLE` to `PH_MODE`.
- `mode_take`: `PH_MODE` to `PH_STREAM`.
- `cs_end`: from any phase back to `PH_IDLE`.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released: `phase` is 0, `cur_addr` is 0, `dummy_clks` is 2, `skip_opcode` is 0, and windowing is disabled.
- R2: A `start` pulse in phase 0 without `cs_end` sets `cur_addr` to `start_addr` and `phase` to 1 one cycle later. A `start` in any other phase is ignored. A `start` in the same cycle as `cs_end` is also ignored.
- R3: With windowing disabled, each accepted step sets `cur_addr` to `cur_addr+1`, modulo 2^ADDR_W. The count crosses 256-byte page boundaries freely.
- R4: With windowing enabled and code c, the window length is L = 8<<c. Each accepted step increments the address within its aligned L-byte block. From the last byte of the block, the step returns to the first byte of the block. Bits above the window never change.
- R5: `wrap_we` loads `wrap_cfg`. Bit 2 set means windowing is disabled, and bits 1:0 are the code c. The new setting governs steps from the next cycle onward. A step in the same cycle as the write still uses the old setting. The setting persists across bursts.
- R6: `dummy_we` loads `dummy_sel`. One cycle later, `dummy_clks` equals 2*`dummy_sel`+2.
- R7: In phase 1, `mode_valid` without `cs_end` moves the phase to 2. On that same edge, it sets `skip_opcode` to 1 if `mode_bits[5:4]` is 2'b10, and to 0 otherwise. A `mode_valid` in any other phase changes nothing.
- R8: `byte_step` is accepted only in phase 2. Outside phase 2, `cur_addr` holds.
- R9: `cs_end` returns the phase to 0 on the next cycle from any phase. It takes priority over a same-cycle `byte_step`, which is then dropped. `cur_addr` and `skip_opcode` are retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a burst at `start_addr` |
| start_addr | input | ADDR_W | First byte address of the burst |
| mode_valid | input | 1 | Mode byte present on `mode_bits` |
| mode_bits | input | 8 | Mode byte captured after the address |
| byte_step | input | 1 | One data byte has been delivered |
| cs_end | input | 1 | Chip select released |
| wrap_we | input | 1 | Write strobe for the window setting |
| wrap_cfg | input | 3 | Bit 2 disables windowing; bits 1:0 are the window code |
| dummy_we | input | 1 | Write strobe for the dummy-clock selection |
| dummy_sel | input | 2 | Dummy-clock selection |
| phase | output | 2 | Current phase (0 idle, 1 mode, 2 stream) |
| cur_addr | output | ADDR_W | Current byte address |
| dummy_clks | output | 4 | Dummy clocks to insert before data |
| skip_opcode | output | 1 | Next access may omit its opcode |

## Verification
An address step and a rewrite of the window setting can land on the same clock edge. The step on that edge must still follow the old setting, and the following steps must follow the new one. The bench provokes this mid-burst by writing a new window code together with `byte_step`, at an address where the old and new settings give different results. A behavioural model that applies the pending step before absorbing the configuration judges every cycle. A second same-edge case, a step dropped under `cs_end`, is also exercised.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_MODE   = 2'd1,
        PH_STREAM = 2'd2
    } phase_e;

    localparam logic [1:0] CONT_KEY = 2'b10;

    function automatic logic [3:0] dummy_count(input logic [1:0] sel);
        return {1'b0, sel, 1'b0} + 4'd2;
    endfunction

endpackage

// File: rtl/burst_cfg_regs.sv
module burst_cfg_regs
    import burst_addr_pkg::*;
#(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap_we,
    input  logic [CODE_W:0]   wrap_in,
    input  logic              dummy_we,
    input  logic [1:0]        dummy_in,
    output logic              wrap_on,
    output logic [CODE_W-1:0] wrap_code,
    output logic [3:0]        dummy_clks
);

    logic [1:0] dsel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wrap_on   <= 1'b0;
            wrap_code <= '0;
        end else if (wrap_we) begin
            wrap_on   <= ~wrap_in[CODE_W];
            wrap_code <= wrap_in[CODE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dsel_q <= 2'b00;
        end else if (dummy_we) begin
            dsel_q <= dummy_in;
        end
    end

    always_comb begin
        dummy_clks = dummy_count(dsel_q);
    end

endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr #(
    parameter int ADDR_W     = 32,
    parameter int NUM_WIN    = 4,
    parameter int MIN_WIN_LG = 3
) (
    input  logic [ADDR_W-1:0]           cur,
    input  logic                        wrap_on,
    input  logic [$clog2(NUM_WIN)-1:0]  wrap_code,
    output logic [ADDR_W-1:0]           nxt
);

    logic [ADDR_W-1:0] inc;
    logic [ADDR_W-1:0] cand [NUM_WIN];

    assign inc = cur + {{(ADDR_W-1){1'b0}}, 1'b1};

    for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
        localparam int LG = MIN_WIN_LG + k;
        assign cand[k] = {cur[ADDR_W-1:LG], inc[LG-1:0]};
    end

    assign nxt = wrap_on ? cand[wrap_code] : inc;

endmodule

// File: rtl/burst_cont_track.sv
module burst_cont_track
    import burst_addr_pkg::*;
#(
    parameter int MODE_W = 8,
    parameter int KEY_LO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [MODE_W-1:0] bits,
    output logic              skip
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            skip <= 1'b0;
        end else if (take) begin
            skip <= (bits[KEY_LO+1:KEY_LO] == CONT_KEY);
        end
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              mode_valid,
    input  logic [7:0]        mode_bits,
    input  logic              byte_step,
    input  logic              cs_end,
    input  logic              wrap_we,
    input  logic [2:0]        wrap_cfg,
    input  logic              dummy_we,
    input  logic [1:0]        dummy_sel,
    output logic [1:0]        phase,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [3:0]        dummy_clks,
    output logic              skip_opcode
);

    localparam int NUM_WIN    = 4;
    localparam int MIN_WIN_LG = 3;
    localparam int CODE_W     = $clog2(NUM_WIN);

    phase_e state_q, state_d;

    logic              wrap_on;
    logic [CODE_W-1:0] wrap_code;
    logic [ADDR_W-1:0] addr_nxt;
    logic              load_go;
    logic              step_go;
    logic              mode_take;

    assign load_go   = (state_q == PH_IDLE)   && start      && !cs_end;
    assign step_go   = (state_q == PH_STREAM) && byte_step  && !cs_end;
    assign mode_take = (state_q == PH_MODE)   && mode_valid && !cs_end;

    burst_cfg_regs #(.CODE_W(CODE_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap_we    (wrap_we),
        .wrap_in    (wrap_cfg),
        .dummy_we   (dummy_we),
        .dummy_in   (dummy_sel),
        .wrap_on    (wrap_on),
        .wrap_code  (wrap_code),
        .dummy_clks (dummy_clks)
    );

    burst_next_addr #(
        .ADDR_W     (ADDR_W),
        .NUM_WIN    (NUM_WIN),
        .MIN_WIN_LG (MIN_WIN_LG)
    ) u_next (
        .cur       (cur_addr),
        .wrap_on   (wrap_on),
        .wrap_code (wrap_code),
        .nxt       (addr_nxt)
    );

    burst_cont_track #(.MODE_W(8), .KEY_LO(4)) u_cont (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (mode_take),
        .bits  (mode_bits),
        .skip  (skip_opcode)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: start, mode_take, cs_end
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: begin
                if (load_go) state_d = PH_MODE;
            end
            PH_MODE: begin
                if (cs_end)         state_d = PH_IDLE;
                else if (mode_take) state_d = PH_STREAM;
            end
            PH_STREAM: begin
                if (cs_end) state_d = PH_IDLE;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // outputs: address register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
        end else if (load_go) begin
            cur_addr <= start_addr;
        end else if (step_go) begin
            cur_addr <= addr_nxt;
        end
    end

    assign phase = state_q;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] start_addr,
    input logic              mode_valid,
    input logic              byte_step,
    input logic              cs_end,
    input logic [1:0]        phase,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [3:0]        dummy_clks,
    input logic              skip_opcode,
    input logic              wrap_on
);

    localparam int TOP_LG = 6;

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 2'd3); // R2

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0 && start && !cs_end) |=> (cur_addr == $past(start_addr) && phase == 2'd1)); // R2

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && byte_step && !cs_end && !wrap_on) |=> cur_addr == $past(cur_addr) + 1'b1); // R3

    AST_WINDOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && byte_step && !cs_end && wrap_on) |=> (cur_addr >> TOP_LG) == ($past(cur_addr) >> TOP_LG)); // R4

    AST_DUMMY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (dummy_clks >= 4'd2 && dummy_clks <= 4'd8 && !dummy_clks[0])); // R6

    AST_SKIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase == 2'd1 && mode_valid && !cs_end) |=> $stable(skip_opcode)); // R7

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(phase == 2'd2 && byte_step) && !(phase == 2'd0 && start)) |=> $stable(cur_addr)); // R8

    AST_CS_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_end |=> (phase == 2'd0 && $stable(cur_addr))); // R9

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_addr  (start_addr),
    .mode_valid  (mode_valid),
    .byte_step   (byte_step),
    .cs_end      (cs_end),
    .phase       (phase),
    .cur_addr    (cur_addr),
    .dummy_clks  (dummy_clks),
    .skip_opcode (skip_opcode),
    .wrap_on     (wrap_on)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic        mode_valid = 1'b0;
    logic [7:0]  mode_bits = '0;
    logic        byte_step = 1'b0;
    logic        cs_end = 1'b0;
    logic        wrap_we = 1'b0;
    logic [2:0]  wrap_cfg = '0;
    logic        dummy_we = 1'b0;
    logic [1:0]  dummy_sel = '0;
    logic [1:0]  phase;
    logic [31:0] cur_addr;
    logic [3:0]  dummy_clks;
    logic        skip_opcode;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic [31:0] m_addr;
    int          m_ph;
    bit          m_wrap_en;
    int          m_code;
    int          m_dsel;
    bit          m_skip;
    longint      a, base, len;

    always #10 clk = ~clk;

    burst_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .mode_valid(mode_valid), .mode_bits(mode_bits), .byte_step(byte_step),
        .cs_end(cs_end), .wrap_we(wrap_we), .wrap_cfg(wrap_cfg),
        .dummy_we(dummy_we), .dummy_sel(dummy_sel), .phase(phase),
        .cur_addr(cur_addr), .dummy_clks(dummy_clks), .skip_opcode(skip_opcode)
    );

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_addr = 0; m_ph = 0; m_wrap_en = 0; m_code = 0; m_dsel = 0; m_skip = 0;
        end else begin
            if (m_ph == 2 && byte_step && !cs_end) begin
                a = longint'(m_addr);
                if (!m_wrap_en) begin
                    m_addr = m_addr + 32'd1;
                end else begin
                    len = 8 << m_code;
                    base = a - (a % len);
                    m_addr = 32'(base + ((a - base + 1) % len));
                end
            end
            if (cs_end) begin
                m_ph = 0;
            end else if (m_ph == 0 && start) begin
                m_addr = start_addr; m_ph = 1;
            end else if (m_ph == 1 && mode_valid) begin
                m_skip = (mode_bits[5:4] == 2'b10); m_ph = 2;
            end
            if (wrap_we) begin m_wrap_en = !wrap_cfg[2]; m_code = int'(wrap_cfg[1:0]); end
            if (dummy_we) m_dsel = int'(dummy_sel);
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            cycles++;
            checks++;
            if (cur_addr !== m_addr || int'(phase) != m_ph ||
                int'(dummy_clks) != 2 * m_dsel + 2 || skip_opcode !== m_skip) begin
                errors++;
                $display("FAIL %s: addr=%h ph=%0d dummy=%0d skip=%0b expected addr=%h ph=%0d dummy=%0d skip=%0b",
                         cur_req, cur_addr, phase, dummy_clks, skip_opcode,
                         m_addr, m_ph, 2 * m_dsel + 2, m_skip);
            end
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual hung, expected completion");
                done = 1;
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_burst(input logic [31:0] ad, input logic [7:0] mb);
        start = 1; start_addr = ad; cyc(); start = 0;
        mode_valid = 1; mode_bits = mb; cyc(); mode_valid = 0;
    endtask

    task automatic steps(input int n);
        byte_step = 1; cyc(n); byte_step = 0;
    endtask

    task automatic end_burst();
        cs_end = 1; cyc(); cs_end = 0; cyc();
    endtask

    initial begin
        cur_req = "R1";
        cyc(3);
        rst_n = 1;
        cyc(2);

        cur_req = "R8";
        steps(2);
        mode_valid = 1; mode_bits = 8'hA0; cyc(); mode_valid = 0;

        cur_req = "R2";
        start = 1; start_addr = 32'h55; cs_end = 1; cyc(); start = 0; cs_end = 0; cyc();
        start = 1; start_addr = 32'h0000_00FC; cyc(); start = 0;
        cur_req = "R8";
        steps(2);
        cur_req = "R2";
        start = 1; start_addr = 32'h777; cyc(); start = 0;

        cur_req = "R7";
        mode_valid = 1; mode_bits = 8'hA0; cyc(); mode_valid = 0;
        mode_valid = 1; mode_bits = 8'hF0; cyc(); mode_valid = 0;

        cur_req = "R3";
        steps(9);

        cur_req = "R9";
        byte_step = 1; cs_end = 1; cyc(); byte_step = 0; cs_end = 0; cyc(2);

        cur_req = "R7";
        begin_burst(32'h1000, 8'hF0);
        end_burst();
        begin_burst(32'h1000, 8'h20);
        end_burst();

        cur_req = "R4";
        for (int c = 0; c < 4; c++) begin
            wrap_we = 1; wrap_cfg = 3'(c); cyc(); wrap_we = 0;
            begin_burst(32'h0002_3A35 + 32'(c * 3), 8'hA0);
            steps(70);
            end_burst();
        end

        cur_req = "R5";
        wrap_we = 1; wrap_cfg = 3'b000; cyc(); wrap_we = 0;
        begin_burst(32'h0000_0205, 8'hA0);
        steps(2);
        byte_step = 1; wrap_we = 1; wrap_cfg = 3'b011; cyc(); wrap_we = 0;
        cyc(4); byte_step = 0;
        byte_step = 1; wrap_we = 1; wrap_cfg = 3'b100; cyc(); wrap_we = 0;
        cyc(70); byte_step = 0;
        end_burst();

        cur_req = "R3";
        begin_burst(32'hFFFF_FFFD, 8'h00);
        steps(5);
        end_burst();

        cur_req = "R6";
        for (int s = 3; s >= 0; s--) begin
            dummy_we = 1; dummy_sel = 2'(s); cyc(); dummy_we = 0; cyc();
        end
        dummy_we = 1; dummy_sel = 2'd2; cyc(); dummy_we = 0; cyc(2);

        cur_req = "R9";
        begin_burst(32'h4000, 8'hA0);
        steps(3);
        cs_end = 1; cyc(); cs_end = 0;
        start = 1; start_addr = 32'h9; cyc(); start = 0;
        cs_end = 1; cyc(); cs_end = 0; cyc(2);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule